// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block sits between a byte-wide host bus and the two channels of a serial controller. Each channel exposes only two bus locations: a control port and a data port. Most registers are reached indirectly. A control write made while a channel's register pointer is zero loads a new pointer and may carry a command. The next control access to that channel, read or write, reaches the register the pointer names. The pointer then falls back to zero.

The block keeps the sixteen write registers of each channel and decodes the reset commands carried by the master control register. Those commands can clear one channel or both. The block also runs a baud tick generator for each channel, driven by a sixteen-bit time constant. The serializer and the interrupt logic are not part of this block. It feeds them through one-cycle strobes: transmit start, line-parameter update, reset-highest-in-service, and channel reset.

Top module: `dual_serial_regif`

## Requirements
- R1: Address bit [ADDR_SHIFT] selects the port, with 0 for control and 1 for data. Address bit [ADDR_SHIFT+1] selects the channel, with 0 for channel B and 1 for channel A. With ADDR_SHIFT=1, channel B control is at offset 0, channel B data at 2, channel A control at 4 and channel A data at 6.
- R2: A control write made while the channel's pointer is 0 loads the pointer from data bits 2:0. When the command field in bits 5:3 is 3'b001, 8 is added to that value.
- R3: A control write made while the pointer is non-zero stores the byte in the pointed write register. A control read made while the pointer is non-zero returns the pointed read register. In both cases the pointer is 0 on the following cycle.
- R4: Read registers 12 and 13 return the time-constant low byte and high byte last written to write registers 12 and 13. Any other pointed read register returns 8'h00.
- R5: A write to register 9 acts on its bits 7:6. The value 2'b01 resets channel B, 2'b10 resets channel A and 2'b11 resets both, whichever channel received the write. A reset clears that channel's write registers, its pointer and its transmit holding byte, and restarts its baud counter. It raises that channel's chan_rst for one cycle. A reset command is not stored. The value 2'b00 is stored as a plain register write.
- R6: A control write made while the pointer is 0 with command field 3'b111 pulses that channel's ius_clr for one cycle.
- R7: A write to register 3, 4, 5, 12 or 13 pulses that channel's param_upd for one cycle.
- R8: Once the pipeline settles, baud_tick of a channel pulses once every 2*(TC+2) clocks, where TC is {reg13, reg12}. A write to either time-constant byte reloads the counter at once.
- R9: A data-port write loads the channel's tx_hold and pulses tx_start for one cycle. A data-port read returns that channel's rx byte input. Data accesses leave the pointer unchanged.
- R10: After reset, all strobes and ticks are low, tx_hold is 0, both pointers are 0 and both time constants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_SHIFT+2 | Bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address and pointer |
| rx_byte_b | input | 8 | Received byte of channel B |
| rx_byte_a | input | 8 | Received byte of channel A |
| tx_hold_b | output | 8 | Transmit holding byte of channel B |
| tx_hold_a | output | 8 | Transmit holding byte of channel A |
| tx_start_b | output | 1 | Transmit start strobe of channel B |
| tx_start_a | output | 1 | Transmit start strobe of channel A |
| param_upd_b | output | 1 | Line-parameter update strobe of channel B |
| param_upd_a | output | 1 | Line-parameter update strobe of channel A |
| ius_clr_b | output | 1 | Reset-highest-in-service strobe of channel B |
| ius_clr_a | output | 1 | Reset-highest-in-service strobe of channel A |
| chan_rst_b | output | 1 | Channel B reset strobe |
| chan_rst_a | output | 1 | Channel A reset strobe |
| baud_tick_b | output | 1 | Baud tick of channel B |
| baud_tick_a | output | 1 | Baud tick of channel A |

## Verification
The assertions assume that the host never raises bus_wr and bus_rd in the same cycle. One property checks this directly. The causal checks also assume that every strobe lasts one cycle, so that a pulse can be traced back to a single access the cycle before. The stimulus tasks keep within both assumptions: each issues exactly one read or one write, followed by an idle cycle. The stimulus also reaches register 9 and the time-constant registers only through a proper pointer load, so every write lands on the register the sequence intends.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_IDX_W = 4;
  localparam int NUM_WREGS = 1 << REG_IDX_W;
  localparam int TC_W      = 2 * BYTE_W;
  localparam int NUM_CH    = 2;

  localparam logic [REG_IDX_W-1:0] REG_RXCTL  = 4'd3;
  localparam logic [REG_IDX_W-1:0] REG_TXCTL1 = 4'd4;
  localparam logic [REG_IDX_W-1:0] REG_TXCTL2 = 4'd5;
  localparam logic [REG_IDX_W-1:0] REG_MASTER = 4'd9;
  localparam logic [REG_IDX_W-1:0] REG_TC_LO  = 4'd12;
  localparam logic [REG_IDX_W-1:0] REG_TC_HI  = 4'd13;

  localparam logic [2:0] CMD_PT_HIGH = 3'b001;
  localparam logic [2:0] CMD_IUS_CLR = 3'b111;

  typedef enum logic [1:0] {
    RST_NONE = 2'b00,
    RST_CH_B = 2'b01,
    RST_CH_A = 2'b10,
    RST_BOTH = 2'b11
  } rst_cmd_e;

  // pointer loaded by a command write at pointer zero
  function automatic logic [REG_IDX_W-1:0] next_pointer(input logic [BYTE_W-1:0] cmd_byte);
    return {(cmd_byte[5:3] == CMD_PT_HIGH), cmd_byte[2:0]};
  endfunction

  function automatic logic is_param_reg(input logic [REG_IDX_W-1:0] idx);
    return (idx == REG_RXCTL) || (idx == REG_TXCTL1) || (idx == REG_TXCTL2) ||
           (idx == REG_TC_LO) || (idx == REG_TC_HI);
  endfunction

  // counter reload: (time constant + 2) states => load TC+1, count to 0
  function automatic logic [TC_W:0] baud_reload(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {1'b0, hi, lo} + {{TC_W{1'b0}}, 1'b1};
  endfunction

  // bit 0 = channel B, bit 1 = channel A
  function automatic logic [NUM_CH-1:0] reset_targets(input logic [BYTE_W-1:0] val);
    case (rst_cmd_e'(val[7:6]))
      RST_CH_B: return 2'b01;
      RST_CH_A: return 2'b10;
      RST_BOTH: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dsr_chan.sv
module dsr_chan
  import dsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic                 is_data,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic [BYTE_W-1:0]    rx_byte,
  input  logic                 rst_req,
  output logic [BYTE_W-1:0]    rdata,
  output logic [BYTE_W-1:0]    tx_hold,
  output logic                 tx_start,
  output logic                 param_upd,
  output logic                 ius_clr,
  output logic                 chan_rst,
  output logic [REG_IDX_W-1:0] ptr,
  output logic [NUM_CH-1:0]    rst_cmd,
  output logic                 tc_load,
  output logic [TC_W:0]        tc_load_val,
  output logic [TC_W-1:0]      tc_word
);
  logic [BYTE_W-1:0] wreg [NUM_WREGS];

  logic ctrl_wr, ctrl_rd, reg_wr, ptr_zero;

  assign ctrl_wr  = acc_wr && !is_data;
  assign ctrl_rd  = acc_rd && !is_data;
  assign ptr_zero = (ptr == '0);
  assign reg_wr   = ctrl_wr && !ptr_zero;

  assign rst_cmd = (reg_wr && ptr == REG_MASTER) ? reset_targets(wdata) : '0;
  assign tc_load = reg_wr && (ptr == REG_TC_LO || ptr == REG_TC_HI);
  assign tc_word = {wreg[REG_TC_HI], wreg[REG_TC_LO]};
  assign tc_load_val = baud_reload((ptr == REG_TC_LO) ? wdata : wreg[REG_TC_LO],
                                   (ptr == REG_TC_HI) ? wdata : wreg[REG_TC_HI]);

  always_comb begin
    if (is_data) begin
      rdata = rx_byte;
    end else begin
      case (ptr)
        REG_TC_LO: rdata = wreg[REG_TC_LO];
        REG_TC_HI: rdata = wreg[REG_TC_HI];
        default:   rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WREGS; i++) wreg[i] <= '0;
      ptr       <= '0;
      tx_hold   <= '0;
      tx_start  <= 1'b0;
      param_upd <= 1'b0;
      ius_clr   <= 1'b0;
      chan_rst  <= 1'b0;
    end else begin
      tx_start  <= 1'b0;
      param_upd <= 1'b0;
      ius_clr   <= 1'b0;
      chan_rst  <= 1'b0;
      if (rst_req) begin
        for (int i = 0; i < NUM_WREGS; i++) wreg[i] <= '0;
        ptr      <= '0;
        tx_hold  <= '0;
        chan_rst <= 1'b1;
      end else begin
        if (acc_wr && is_data) begin
          tx_hold  <= wdata;
          tx_start <= 1'b1;
        end
        if (ctrl_wr) begin
          if (ptr_zero) begin
            ptr     <= next_pointer(wdata);
            ius_clr <= (wdata[5:3] == CMD_IUS_CLR);
          end else begin
            if (rst_cmd == '0) wreg[ptr] <= wdata;
            param_upd <= is_param_reg(ptr);
            ptr       <= '0;
          end
        end
        if (ctrl_rd && !ptr_zero) ptr <= '0;
      end
    end
  end
endmodule

// File: rtl/dsr_baud.sv
module dsr_baud
  import dsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            rst_req,
  input  logic            load,
  input  logic [TC_W:0]   load_val,
  input  logic [TC_W-1:0] tc_word,
  output logic            tick
);
  localparam logic [TC_W:0] CNT_AFTER_RST = {{TC_W{1'b0}}, 1'b1};

  logic [TC_W:0] cnt;
  logic          at_zero;

  assign at_zero = (cnt == '0);
  assign tick    = en && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_AFTER_RST;
    end else if (rst_req) begin
      cnt <= CNT_AFTER_RST;
    end else if (load) begin
      cnt <= load_val;
    end else if (en) begin
      cnt <= at_zero ? baud_reload(tc_word[BYTE_W-1:0], tc_word[TC_W-1:BYTE_W])
                     : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
#(
  parameter int ADDR_SHIFT = 1,
  localparam int AW = ADDR_SHIFT + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte_b,
  input  logic [BYTE_W-1:0] rx_byte_a,
  output logic [BYTE_W-1:0] tx_hold_b,
  output logic [BYTE_W-1:0] tx_hold_a,
  output logic              tx_start_b,
  output logic              tx_start_a,
  output logic              param_upd_b,
  output logic              param_upd_a,
  output logic              ius_clr_b,
  output logic              ius_clr_a,
  output logic              chan_rst_b,
  output logic              chan_rst_a,
  output logic              baud_tick_b,
  output logic              baud_tick_a
);
  localparam int CH_B = 0;
  localparam int CH_A = 1;

  logic port_sel, chan_sel, half_q;

  assign port_sel = bus_addr[ADDR_SHIFT];
  assign chan_sel = bus_addr[ADDR_SHIFT+1];

  logic [BYTE_W-1:0]    rx_w     [NUM_CH];
  logic [BYTE_W-1:0]    rdata_w  [NUM_CH];
  logic [BYTE_W-1:0]    txh_w    [NUM_CH];
  logic [REG_IDX_W-1:0] ptr_w    [NUM_CH];
  logic [NUM_CH-1:0]    rcmd_w   [NUM_CH];
  logic [TC_W:0]        ldval_w  [NUM_CH];
  logic [TC_W-1:0]      tc_w     [NUM_CH];
  logic [NUM_CH-1:0]    txs_w, par_w, ius_w, crst_w, tcld_w, tick_w, rst_req;

  // named event wires for the checker
  logic [REG_IDX_W-1:0] ptr_b, ptr_a;
  logic [TC_W-1:0]      tc_b, tc_a;

  assign rx_w[CH_B] = rx_byte_b;
  assign rx_w[CH_A] = rx_byte_a;
  assign rst_req    = rcmd_w[CH_B] | rcmd_w[CH_A];

  // shared divide-by-two channel clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic CH_BIT = 1'(g);
    logic hit;
    assign hit = (chan_sel == CH_BIT);

    dsr_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_wr      (bus_wr && hit),
      .acc_rd      (bus_rd && hit),
      .is_data     (port_sel),
      .wdata       (bus_wdata),
      .rx_byte     (rx_w[g]),
      .rst_req     (rst_req[g]),
      .rdata       (rdata_w[g]),
      .tx_hold     (txh_w[g]),
      .tx_start    (txs_w[g]),
      .param_upd   (par_w[g]),
      .ius_clr     (ius_w[g]),
      .chan_rst    (crst_w[g]),
      .ptr         (ptr_w[g]),
      .rst_cmd     (rcmd_w[g]),
      .tc_load     (tcld_w[g]),
      .tc_load_val (ldval_w[g]),
      .tc_word     (tc_w[g])
    );

    dsr_baud u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (half_q),
      .rst_req  (rst_req[g]),
      .load     (tcld_w[g]),
      .load_val (ldval_w[g]),
      .tc_word  (tc_w[g]),
      .tick     (tick_w[g])
    );
  end

  assign bus_rdata   = rdata_w[chan_sel];
  assign tx_hold_b   = txh_w[CH_B];
  assign tx_hold_a   = txh_w[CH_A];
  assign tx_start_b  = txs_w[CH_B];
  assign tx_start_a  = txs_w[CH_A];
  assign param_upd_b = par_w[CH_B];
  assign param_upd_a = par_w[CH_A];
  assign ius_clr_b   = ius_w[CH_B];
  assign ius_clr_a   = ius_w[CH_A];
  assign chan_rst_b  = crst_w[CH_B];
  assign chan_rst_a  = crst_w[CH_A];
  assign baud_tick_b = tick_w[CH_B];
  assign baud_tick_a = tick_w[CH_A];
  assign ptr_b       = ptr_w[CH_B];
  assign ptr_a       = ptr_w[CH_A];
  assign tc_b        = tc_w[CH_B];
  assign tc_a        = tc_w[CH_A];
endmodule

// File: rtl/dsr_regif_chk.sv
module dsr_regif_chk
  import dsr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 port_sel,
  input logic                 chan_sel,
  input logic [BYTE_W-1:0]    bus_wdata,
  input logic [REG_IDX_W-1:0] ptr_b,
  input logic [REG_IDX_W-1:0] ptr_a,
  input logic [TC_W-1:0]      tc_b,
  input logic [TC_W-1:0]      tc_a,
  input logic                 tx_start_b,
  input logic                 tx_start_a,
  input logic                 ius_clr_b,
  input logic                 param_upd_a,
  input logic                 chan_rst_b,
  input logic                 chan_rst_a,
  input logic                 baud_tick_b,
  input logic                 baud_tick_a
);
  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R1

  AST_PTR_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !port_sel && !chan_sel && ptr_b != '0) |=> (ptr_b == '0)); // R3

  AST_PTR_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !port_sel && chan_sel && ptr_a != '0) |=> (ptr_a == '0)); // R3

  AST_RST_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_b |-> (tc_b == '0 && ptr_b == '0)); // R5

  AST_RST_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_a |-> (tc_a == '0 && ptr_a == '0)); // R5

  AST_IUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ius_clr_b |-> $past(bus_wr && !port_sel && !chan_sel && ptr_b == '0 &&
                        bus_wdata[5:3] == CMD_IUS_CLR)); // R6

  AST_PARAM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    param_upd_a |-> $past(bus_wr && !port_sel && chan_sel && is_param_reg(ptr_a))); // R7

  AST_TICK_SPACED_B: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick_b |=> !baud_tick_b); // R8

  AST_TICK_SPACED_A: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick_a |=> !baud_tick_a); // R8

  AST_TXSTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_a |-> $past(bus_wr && port_sel && chan_sel)); // R9

  AST_TXSTART_CAUSE_B: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_b |-> $past(bus_wr && port_sel && !chan_sel)); // R9
endmodule

bind dual_serial_regif dsr_regif_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .port_sel    (port_sel),
  .chan_sel    (chan_sel),
  .bus_wdata   (bus_wdata),
  .ptr_b       (ptr_b),
  .ptr_a       (ptr_a),
  .tc_b        (tc_b),
  .tc_a        (tc_a),
  .tx_start_b  (tx_start_b),
  .tx_start_a  (tx_start_a),
  .ius_clr_b   (ius_clr_b),
  .param_upd_a (param_upd_a),
  .chan_rst_b  (chan_rst_b),
  .chan_rst_a  (chan_rst_a),
  .baud_tick_b (baud_tick_b),
  .baud_tick_a (baud_tick_a)
);

// File: tb/dual_serial_regif_test.sv
module dual_serial_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 1;
  localparam int AW = SH + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] rx_byte_b = 8'h5A, rx_byte_a = 8'hA5;
  logic [7:0] tx_hold_b, tx_hold_a;
  logic tx_start_b, tx_start_a, param_upd_b, param_upd_a, ius_clr_b, ius_clr_a;
  logic chan_rst_b, chan_rst_a, baud_tick_b, baud_tick_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_serial_regif #(.ADDR_SHIFT(SH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte_b(rx_byte_b), .rx_byte_a(rx_byte_a),
    .tx_hold_b(tx_hold_b), .tx_hold_a(tx_hold_a), .tx_start_b(tx_start_b), .tx_start_a(tx_start_a),
    .param_upd_b(param_upd_b), .param_upd_a(param_upd_a), .ius_clr_b(ius_clr_b), .ius_clr_a(ius_clr_a),
    .chan_rst_b(chan_rst_b), .chan_rst_a(chan_rst_a), .baud_tick_b(baud_tick_b), .baud_tick_a(baud_tick_a));

  // ---------------- behavioural reference model ----------------
  int   m_ptr [2] = '{0, 0};
  int   m_reg [2][16];
  int   m_txh [2] = '{0, 0};
  bit   m_txs [2], m_par [2], m_ius [2], m_rst [2];
  int   m_cnt [2] = '{1, 1};
  bit   m_half = 0;

  initial for (int c = 0; c < 2; c++) for (int r = 0; r < 16; r++) m_reg[c][r] = 0;

  function automatic int tc_of(int c);
    return m_reg[c][13] * 256 + m_reg[c][12];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_half = 0;
      for (int c = 0; c < 2; c++) begin
        m_ptr[c] = 0; m_txh[c] = 0; m_cnt[c] = 1;
        m_txs[c] = 0; m_par[c] = 0; m_ius[c] = 0; m_rst[c] = 0;
        for (int r = 0; r < 16; r++) m_reg[c][r] = 0;
      end
    end else begin
      automatic bit en_old = m_half;
      automatic int ch = int'(bus_addr[SH+1]);
      automatic bit dp = bus_addr[SH];
      automatic int wd = int'(bus_wdata);
      automatic int mask = 0;
      m_half = !m_half;
      for (int c = 0; c < 2; c++) begin
        m_txs[c] = 0; m_par[c] = 0; m_ius[c] = 0; m_rst[c] = 0;
      end
      if (bus_wr && !dp && m_ptr[ch] == 9) mask = wd / 64;  // bit0 = B, bit1 = A
      for (int c = 0; c < 2; c++) begin
        if (mask[c]) m_cnt[c] = 1;
        else if (bus_wr && !dp && ch == c && m_ptr[c] == 12) m_cnt[c] = m_reg[c][13] * 256 + wd + 1;
        else if (bus_wr && !dp && ch == c && m_ptr[c] == 13) m_cnt[c] = wd * 256 + m_reg[c][12] + 1;
        else if (en_old) m_cnt[c] = (m_cnt[c] == 0) ? tc_of(c) + 1 : m_cnt[c] - 1;
      end
      if (!mask[ch]) begin
        if (bus_wr && dp) begin m_txh[ch] = wd; m_txs[ch] = 1; end
        if (bus_wr && !dp) begin
          if (m_ptr[ch] == 0) begin
            m_ius[ch] = ((wd / 8) % 8 == 7);
            m_ptr[ch] = (wd % 8) + (((wd / 8) % 8 == 1) ? 8 : 0);
          end else begin
            if (!(m_ptr[ch] == 9 && mask != 0)) m_reg[ch][m_ptr[ch]] = wd;
            m_par[ch] = (m_ptr[ch] inside {3, 4, 5, 12, 13});
            m_ptr[ch] = 0;
          end
        end
        if (bus_rd && !dp && m_ptr[ch] != 0) m_ptr[ch] = 0;
      end
      for (int c = 0; c < 2; c++) if (mask[c]) begin
        m_ptr[c] = 0; m_txh[c] = 0; m_rst[c] = 1;
        for (int r = 0; r < 16; r++) m_reg[c][r] = 0;
      end
    end
  end

  // ---------------- checking ----------------
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_tag = "R1";
  bit done = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    cmp("R9", "tx_hold_b", int'(tx_hold_b), m_txh[0]);
    cmp("R9", "tx_hold_a", int'(tx_hold_a), m_txh[1]);
    cmp("R9", "tx_start_b", int'(tx_start_b), int'(m_txs[0]));
    cmp("R9", "tx_start_a", int'(tx_start_a), int'(m_txs[1]));
    cmp("R7", "param_upd_b", int'(param_upd_b), int'(m_par[0]));
    cmp("R7", "param_upd_a", int'(param_upd_a), int'(m_par[1]));
    cmp("R6", "ius_clr_b", int'(ius_clr_b), int'(m_ius[0]));
    cmp("R6", "ius_clr_a", int'(ius_clr_a), int'(m_ius[1]));
    cmp("R5", "chan_rst_b", int'(chan_rst_b), int'(m_rst[0]));
    cmp("R5", "chan_rst_a", int'(chan_rst_a), int'(m_rst[1]));
    cmp("R8", "baud_tick_b", int'(baud_tick_b), int'(m_half && m_cnt[0] == 0));
    cmp("R8", "baud_tick_a", int'(baud_tick_a), int'(m_half && m_cnt[1] == 0));
  endtask

  function automatic int exp_rdata();
    automatic int ch = int'(bus_addr[SH+1]);
    if (bus_addr[SH]) return (ch == 1) ? int'(rx_byte_a) : int'(rx_byte_b);
    if (m_ptr[ch] == 12) return m_reg[ch][12];
    if (m_ptr[ch] == 13) return m_reg[ch][13];
    return 0;
  endfunction

  // one clock: check registered outputs, drive, check read data
  task automatic step(bit wr, bit rd, int ch, bit dp, int d);
    @(negedge clk);
    if (rst_n) check_regs();
    bus_wr = wr; bus_rd = rd;
    bus_addr = AW'((ch * 2 + int'(dp)) << SH);
    bus_wdata = 8'(d);
    #1;
    if (rst_n) cmp(cur_tag, "bus_rdata", int'(bus_rdata), exp_rdata());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask
  task automatic wr(int ch, bit dp, int d); step(1, 0, ch, dp, d); idle(1); endtask
  task automatic rd(int ch, bit dp);        step(0, 1, ch, dp, 0); idle(1); endtask

  // ch: 0 = B, 1 = A
  task automatic set_tc(int ch, int tc);
    wr(ch, 0, 8'h0C); wr(ch, 0, tc % 256);
    wr(ch, 0, 8'h0D); wr(ch, 0, tc / 256);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset state at the ports
    #1;
    cmp("R10", "tx_hold_b after reset", int'(tx_hold_b), 0);
    cmp("R10", "strobes after reset", int'({tx_start_b, tx_start_a, param_upd_b, param_upd_a,
        ius_clr_b, ius_clr_a, chan_rst_b, chan_rst_a, baud_tick_b, baud_tick_a}), 0);
    idle(4);

    cur_tag = "R1";  // data ports of each channel at their decoded offsets
    rd(0, 1); rd(1, 1);
    rx_byte_b = 8'h3C; rx_byte_a = 8'hC3;
    rd(0, 1); rd(1, 1);
    cur_tag = "R9";
    wr(0, 1, 8'h11); wr(1, 1, 8'h22); wr(0, 1, 8'hF0);

    cur_tag = "R2";  // point-high pointer loads and time constants
    set_tc(0, 3);    // B period 10
    set_tc(1, 1);    // A period 6
    cur_tag = "R4";
    wr(0, 0, 8'h0C); rd(0, 0);
    wr(0, 0, 8'h0D); rd(0, 0);
    wr(1, 0, 8'h0C); rd(1, 0);
    wr(1, 0, 8'h07); rd(1, 0);     // unused read register returns 0
    cur_tag = "R3";
    rd(1, 0);                      // pointer back at zero
    wr(0, 0, 8'h04); wr(0, 0, 8'h55);  // R7: tx control write
    wr(1, 0, 8'h03); wr(1, 0, 8'h0F);
    wr(1, 0, 8'h06); wr(1, 0, 8'h77);  // non-parameter register
    wr(0, 0, 8'h02); rd(0, 1); rd(0, 0);  // R9: data read keeps pointer
    cur_tag = "R6";
    wr(1, 0, 8'h38); wr(0, 0, 8'h38);
    idle(60);

    cur_tag = "R5";
    wr(1, 0, 8'h09); wr(1, 0, 8'h40);  // reset B via A
    wr(0, 0, 8'h0C); rd(0, 0);
    wr(1, 0, 8'h0C); rd(1, 0);
    set_tc(0, 2);
    idle(30);
    wr(0, 0, 8'h09); wr(0, 0, 8'h80);  // reset A via B
    wr(1, 0, 8'h0D); rd(1, 0);
    set_tc(1, 4);
    wr(1, 1, 8'h99);
    wr(1, 0, 8'h09); wr(1, 0, 8'hC0);  // reset both
    wr(0, 0, 8'h0C); rd(0, 0);
    wr(0, 0, 8'h09); wr(0, 0, 8'h00);  // stored, no reset

    cur_tag = "R8";
    set_tc(0, 16'h0100);
    set_tc(1, 5);
    idle(1500);
    wr(1, 0, 8'h0C); wr(1, 0, 8'h00);  // reload mid-count
    idle(200);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule